// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is the watchdog of a small microcontroller. It is off after a chip reset. Software turns it on by writing a two-byte key to a restart register. From then on the same key must be written again before the selected timeout runs out. If the key does not arrive in time, the block raises a reset request of fixed length. Once the watchdog is running, software cannot switch it off. Only a chip reset returns it to the off state.

The timebase is the oscillator clock. When the device runs in double-speed mode and the watchdog speed bit is clear, the timebase is halved. A divide-by-six prescaler feeds a counter whose limit is chosen by a 3-bit select field in a program register. The counter keeps its value while the device is powered down. A wake-up through an interrupt, which releases the power-down input, lets the count continue from where it stopped. A wake-up through reset clears the count and switches the watchdog off.

Top module: `wdt_keyed_top`

## Requirements
- R1: After the chip reset (rstN low, active-low, asynchronous) the watchdog is off, wdReset is low and selRd reads 0.
- R2: A write of 0x1E to the restart register (wrSel = 0), followed directly by a write of 0xE1 to the same register, switches the watchdog on if it is off. If it is already running, the same pair clears the prescaler and the counter. The count restarts from the edge that takes the 0xE1 write.
- R3: Once on, the watchdog stays on through any register writes and through power-down. Only rstN switches it off.
- R4: On expiry, wdReset goes high for exactly PULSE_LEN (default 96) oscillator cycles.
- R5: With select value n and a full-rate timebase, wdReset rises exactly 6·(2^(BASE_EXP+n) − 1) oscillator cycles after the clearing edge. After an expiry the count restarts from zero.
- R6: When dblSpeed = 1 and wdDblBit = 0, each timebase tick takes two oscillator cycles, so the timeout doubles. When dblSpeed = 0, or when wdDblBit = 1, the timebase is the oscillator clock.
- R7: While pwrDown = 1 the prescaler and the counter hold their values. When pwrDown returns to 0, counting resumes, and the expiry is late by exactly the number of held cycles.
- R8: A rstN pulse during power-down leaves the watchdog off and the count cleared. No wdReset follows.
- R9: A lone 0xE1 has no effect. Any restart-register write other than 0xE1 right after 0xE1's arming byte 0x1E drops the partial key. Such writes neither switch the watchdog on nor clear it.
- R10: A write to the program register (wrSel = 1) stores wrData[2:0], and selRd shows it. The running timeout only takes up the new value at the next key clear or the next expiry.
- R11: If a key clear lands on the same edge as an expiry, the clear wins. No pulse is raised, and the next expiry comes a full timeout later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Chip reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = restart register, 1 = program register |
| wrData | input | 8 | Write data |
| dblSpeed | input | 1 | Device runs in double-speed mode |
| wdDblBit | input | 1 | Watchdog keeps full oscillator rate in double-speed mode |
| pwrDown | input | 1 | Device is in power-down |
| selRd | output | 3 | Stored timeout select |
| wdReset | output | 1 | Reset request pulse |

## Verification
The two functions that can fall on the same edge are a key clear and the counter expiry. The bench enables the watchdog and counts cycles. It then places the 0xE1 write exactly on the edge where the expiry would occur. The result is judged at wdReset: no pulse may appear there, and the next rise must come one full timeout after that edge. A second collision pairs a program-register write with a running count. There the old timeout must still hold, and the new one must apply only from the following expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h1E;
  localparam logic [7:0] KEY_FIRE = 8'hE1;

  typedef struct packed {
    logic clear;  // restart prescaler and counter
    logic tick;   // one timebase period elapsed
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  input  logic             dblSpeed,
  input  logic             wdDblBit,
  input  logic             pwrDown,
  input  logic             overflow,
  output wdtStrobe_t       strobe,
  output logic [SEL_W-1:0] activeSel,
  output logic [SEL_W-1:0] progSel,
  output logic             enabled,
  output logic             rstOut
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          armed;
  logic          phase;
  logic [PW-1:0] pulseCnt;
  logic          restartWr;
  logic          keyHit;
  logic          halfRate;
  logic          running;

  always_comb begin
    restartWr    = wrEn && !wrSel;
    keyHit       = restartWr && armed && (wrData == KEY_FIRE);
    halfRate     = dblSpeed && !wdDblBit;
    running      = enabled && !pwrDown;
    strobe.clear = keyHit;
    strobe.tick  = running && (!halfRate || phase);
  end

  // key detector: arm on 0x1E, fire on 0xE1 directly after
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (restartWr) armed <= (wrData == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       enabled <= 1'b0;
    else if (keyHit) enabled <= 1'b1;
  end

  // half-rate phase for the slow timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    phase <= 1'b0;
    else if (keyHit || !halfRate) phase <= 1'b0;
    else if (running)             phase <= ~phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               progSel <= '0;
    else if (wrEn && wrSel)  progSel <= wrData[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  activeSel <= '0;
    else if (keyHit || overflow) activeSel <= progSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (overflow)        pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - PW'(1);
  end

  assign rstOut = (pulseCnt != '0);

  AST_NO_PULSE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !rstOut); // R1
  AST_STAY_ON: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> enabled); // R3
  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCnt != '0 && !overflow) |=> pulseCnt == $past(pulseCnt) - PW'(1)); // R4
  AST_OVF_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> enabled && !pwrDown); // R7
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRE_DIV  = 6,
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [SEL_W-1:0] activeSel,
  output logic             overflow
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastBeforeLimit;
  logic             preWrap;
  logic             atLast;

  always_comb begin
    lastBeforeLimit = (CNT_W'(1) << (BASE_EXP + int'(activeSel))) - CNT_W'(2);
    preWrap  = strobe.tick && (pre == PRE_W'(PRE_DIV - 1));
    atLast   = (count == lastBeforeLimit);
    overflow = preWrap && atLast && !strobe.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre   <= '0;
      count <= '0;
    end else if (strobe.clear) begin
      pre   <= '0;
      count <= '0;
    end else if (strobe.tick) begin
      pre <= preWrap ? '0 : pre + PRE_W'(1);
      if (preWrap) count <= atLast ? '0 : count + CNT_W'(1);
    end
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clear) |=> $stable(count) && $stable(pre)); // R7
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0) && (pre == '0)); // R2
  AST_CLEAR_BEATS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |-> !overflow); // R11
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int PRE_DIV   = 6,
  parameter int BASE_EXP  = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  input  logic             dblSpeed,
  input  logic             wdDblBit,
  input  logic             pwrDown,
  output logic [SEL_W-1:0] selRd,
  output logic             wdReset
);
  wdtStrobe_t       strobe;
  logic [SEL_W-1:0] activeSel;
  logic             overflow;
  logic             enabled;

  wdt_ctrl #(.SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dblSpeed(dblSpeed), .wdDblBit(wdDblBit), .pwrDown(pwrDown),
    .overflow(overflow), .strobe(strobe), .activeSel(activeSel),
    .progSel(selRd), .enabled(enabled), .rstOut(wdReset)
  );

  wdt_datapath #(.PRE_DIV(PRE_DIV), .BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .activeSel(activeSel),
    .overflow(overflow)
  );

  AST_OFF_NO_KEYCLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !strobe.clear) |=> !enabled); // R9
endmodule

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 5;
  localparam int T0 = 6 * ((1 << BASE) - 1);        // n=0: 186
  localparam int T1 = 6 * ((1 << (BASE + 1)) - 1);  // n=1: 378
  localparam int T2 = 6 * ((1 << (BASE + 2)) - 1);  // n=2: 762

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic dblSpeed = 1'b0, wdDblBit = 1'b0, pwrDown = 1'b0;
  logic [2:0] selRd;
  logic wdReset;

  int nChecks = 0, nFails = 0;
  int kNow = 0, rise1 = -1, rise2 = -1, hiCount = 0;
  logic prevOut = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_keyed_top #(.BASE_EXP(BASE)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dblSpeed(dblSpeed), .wdDblBit(wdDblBit), .pwrDown(pwrDown),
    .selRd(selRd), .wdReset(wdReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    kNow++;
    if (wdReset) hiCount++;
    if (wdReset && !prevOut) begin
      if (rise1 < 0) rise1 = kNow;
      else if (rise2 < 0) rise2 = kNow;
    end
    prevOut = wdReset;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      observe();
    end
  endtask

  task automatic stepTo(input int k);
    while (kNow < k) step(1);
  endtask

  // called at a negedge; write is taken on the next posedge
  task automatic wrReg(input logic sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    observe();
    wrEn = 1'b0;
  endtask

  task automatic chipReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    kNow = 0; rise1 = -1; rise2 = -1; hiCount = 0; prevOut = 1'b0;
  endtask

  // leaves kNow = 0 at the clearing edge
  task automatic enableWd();
    wrReg(1'b0, 8'h1E);
    wrReg(1'b0, 8'hE1);
    kNow = 0; rise1 = -1; rise2 = -1; hiCount = 0;
  endtask

  task automatic testReset();
    chipReset();
    check(wdReset == 1'b0, "R1 reset wdReset", wdReset, 0);
    check(selRd == 3'd0, "R1 reset selRd", selRd, 0);
  endtask

  task automatic testBadKeys();
    chipReset();
    wrReg(1'b0, 8'hE1);
    wrReg(1'b0, 8'h1E);
    wrReg(1'b0, 8'h55);
    wrReg(1'b0, 8'hE1);
    wrReg(1'b0, 8'h1E);
    wrReg(1'b1, 8'h00);   // program write does not disarm, but data still 0
    kNow = 0; rise1 = -1;
    stepTo(T0 + 50);
    // program write after 1E leaves key armed; no E1 followed so stays off
    check(rise1 == -1, "R9 bad keys do not enable", rise1, -1);
  endtask

  task automatic testTimeoutN0();
    chipReset();
    enableWd();
    stepTo(T0 + 110);
    check(rise1 == T0, "R5 n=0 timeout", rise1, T0);
    check(hiCount == 96, "R4 pulse width", hiCount, 96);
    check(wdReset == 1'b0, "R4 pulse ended", wdReset, 0);
  endtask

  task automatic testTimeoutN2();
    chipReset();
    wrReg(1'b1, 8'hFA);   // low bits 3'b010
    check(selRd == 3'd2, "R10 select readback", selRd, 2);
    enableWd();
    stepTo(T2 + 5);
    check(rise1 == T2, "R5 n=2 timeout", rise1, T2);
  endtask

  task automatic testClockModes();
    chipReset();
    dblSpeed = 1'b1; wdDblBit = 1'b0;
    enableWd();
    stepTo(2 * T0 + 5);
    check(rise1 == 2 * T0, "R6 half-rate timebase", rise1, 2 * T0);
    chipReset();
    dblSpeed = 1'b1; wdDblBit = 1'b1;
    enableWd();
    stepTo(T0 + 5);
    check(rise1 == T0, "R6 full rate with speed bit", rise1, T0);
    dblSpeed = 1'b0; wdDblBit = 1'b0;
  endtask

  task automatic testPowerDown();
    chipReset();
    enableWd();
    stepTo(30);
    pwrDown = 1'b1;
    stepTo(80);
    pwrDown = 1'b0;
    stepTo(T0 + 60);
    check(rise1 == T0 + 50, "R7 freeze and resume", rise1, T0 + 50);
    check(rise1 != T0, "R3 still on after power-down", rise1, T0 + 50);
  endtask

  task automatic testResetInPowerDown();
    chipReset();
    enableWd();
    stepTo(40);
    pwrDown = 1'b1;
    stepTo(60);
    chipReset();
    pwrDown = 1'b0;
    stepTo(T0 + 50);
    check(rise1 == -1, "R8 reset during power-down disables", rise1, -1);
  endtask

  task automatic testKicks();
    chipReset();
    enableWd();
    stepTo(40);
    wrReg(1'b0, 8'h1E);
    wrReg(1'b0, 8'hE1);   // clear at edge 42
    stepTo(T0 + 50);
    check(rise1 == 42 + T0, "R2 key clears running count", rise1, 42 + T0);
    chipReset();
    enableWd();
    stepTo(40);
    wrReg(1'b0, 8'h1E);
    wrReg(1'b0, 8'h55);
    wrReg(1'b0, 8'hE1);
    wrReg(1'b1, 8'h00);
    stepTo(T0 + 5);
    check(rise1 == T0, "R9 broken key does not clear", rise1, T0);
  endtask

  task automatic testCollision();
    chipReset();
    enableWd();
    stepTo(T0 - 2);
    wrReg(1'b0, 8'h1E);
    wrReg(1'b0, 8'hE1);   // lands on edge T0
    stepTo(2 * T0 + 5);
    check(rise1 == 2 * T0, "R11 clear wins over expiry", rise1, 2 * T0);
  endtask

  task automatic testSelLatch();
    chipReset();
    enableWd();
    stepTo(10);
    wrReg(1'b1, 8'h01);
    stepTo(T0 + T1 + 5);
    check(rise1 == T0, "R10 new select waits for clear", rise1, T0);
    check(rise2 == T0 + T1, "R10 new select after expiry", rise2, T0 + T1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testBadKeys();
    testTimeoutN0();
    testTimeoutN2();
    testClockModes();
    testPowerDown();
    testResetInPowerDown();
    testKicks();
    testCollision();
    testSelLatch();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule